// File: doc/BRIEF.md
# Event counter with overflow interrupt

This block counts occurrences of one hardware event chosen from a bank of event lines. Software programs which line to watch, which privilege levels may contribute, and optionally a process identifier that the current process must match. It then issues a start command, lets the workload run, issues a stop command and reads the total.

The count register is 16 bits wide. Each time it wraps from all ones to zero it raises an interrupt, so a handler can extend the total in software. The interrupt stays high until it is acknowledged. If a second wrap arrives before the acknowledge, a sticky flag records that an overflow was lost. Software clears that flag explicitly.

All configuration and the count sit in a small register bank with a single write port and a combinational read port.

Top module: `evc_top`

## Requirements
- R1: Only the event line whose index is held in the select register (address 0) is counted, with one increment for each clock cycle in which that line is high and counting is qualified; activity on every other line is ignored.
- R2: Writing the control register (address 1) with bit 0 set starts counting from the following cycle. Writing it with bit 1 set stops counting from the following cycle, and stop takes priority if both bits are set. After a stop the count holds its value and stays readable.
- R3: The mode register (address 2) gates counting by privilege. Bit 0 allows events while `priv_kernel` is 0 (user level), and bit 1 allows events while `priv_kernel` is 1 (kernel level).
- R4: When mode bit 2 is set, an event counts only if `cur_pid` equals the process ID register (address 3). When the bit is clear, `cur_pid` has no effect.
- R5: A qualified event while the count is 0xFFFF makes the count 0x0000 and raises `irq` on the next cycle. `irq` stays high until a cycle with `irq_ack` high, and a wrap in that same cycle keeps it high.
- R6: A wrap while `irq` is high and `irq_ack` is low sets a sticky lost-overflow flag. Writing the control register with bit 2 set clears the flag, and that write leaves the run state unchanged.
- R7: A write to the count register (address 4) loads the written value, and an event in the same cycle is dropped.
- R8: After reset the count is 0, counting is stopped, `irq` and the lost flag are 0, the select and process ID registers are 0, and the mode register is 3 (both privilege levels, no process filter).
- R9: Reading address 1 returns the run state in bit 0, `irq` in bit 1 and the lost flag in bit 2. Addresses 0, 2, 3 and 4 read back their register right-aligned. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| events | input | 8 | Event lines, one bit per event |
| priv_kernel | input | 1 | Current privilege level, 1 for kernel |
| cur_pid | input | 8 | Identifier of the running process |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with its defaults: eight event lines, a 16-bit count and an 8-bit process ID. With eight lines the sweep covers every select value against all eight mode encodings, both privilege levels and a matching and a non-matching process, so each qualification path is exercised exhaustively. Wraps are reached in a few cycles because the count is preloaded through its write port to 0xFFFE or 0xFFFF, which also lets the bench place a second wrap ahead of the acknowledge.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [2:0] {
        ADR_SEL  = 3'd0,
        ADR_CTRL = 3'd1,
        ADR_MODE = 3'd2,
        ADR_PID  = 3'd3,
        ADR_CNT  = 3'd4
    } evc_addr_e;

    typedef struct packed {
        logic pid_en;
        logic kern;
        logic user;
    } evc_mode_t;

    localparam evc_mode_t MODE_RST = '{pid_en: 1'b0, kern: 1'b1, user: 1'b1};

    localparam int CTRL_START   = 0;
    localparam int CTRL_STOP    = 1;
    localparam int CTRL_CLRLOST = 2;

    function automatic logic priv_allows(evc_mode_t m, logic kernel);
        return kernel ? m.kern : m.user;
    endfunction

endpackage

// File: rtl/evc_regs.sv
module evc_regs
    import evc_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int PID_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEL_W-1:0]  sel,
    output evc_mode_t         mode,
    output logic [PID_W-1:0]  pid,
    output logic              run,
    output logic              lost_clr,
    output logic              cnt_wr
);
    logic ctrl_wr;

    assign ctrl_wr  = wr_en && (wr_addr == ADR_CTRL);
    assign cnt_wr   = wr_en && (wr_addr == ADR_CNT);
    assign lost_clr = ctrl_wr && wr_data[CTRL_CLRLOST];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel  <= '0;
            mode <= MODE_RST;
            pid  <= '0;
            run  <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_SEL:  sel  <= wr_data[SEL_W-1:0];
                ADR_MODE: mode <= evc_mode_t'(wr_data[2:0]);
                ADR_PID:  pid  <= wr_data[PID_W-1:0];
                ADR_CTRL: begin
                    if (wr_data[CTRL_STOP])
                        run <= 1'b0;
                    else if (wr_data[CTRL_START])
                        run <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_data[CTRL_STOP]) |=> !run); // R2
    AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_data[CTRL_START] && !wr_data[CTRL_STOP]) |=> run); // R2

endmodule

// File: rtl/evc_qual.sv
module evc_qual
    import evc_pkg::*;
#(
    parameter int NUM_EVENTS = 8,
    parameter int SEL_W      = 3,
    parameter int PID_W      = 8
) (
    input  logic [NUM_EVENTS-1:0] events,
    input  logic [SEL_W-1:0]      sel,
    input  evc_mode_t             mode,
    input  logic [PID_W-1:0]      pid,
    input  logic                  run,
    input  logic                  priv_kernel,
    input  logic [PID_W-1:0]      cur_pid,
    output logic                  inc
);
    logic picked;
    logic pid_ok;

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NUM_EVENTS; i++)
            if (sel == SEL_W'(i))
                picked = events[i];
    end

    assign pid_ok = !mode.pid_en || (cur_pid == pid);
    assign inc    = run && picked && priv_allows(mode, priv_kernel) && pid_ok;

endmodule

// File: rtl/evc_core.sv
module evc_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             irq_ack,
    input  logic             lost_clr,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             lost
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic wrap;

    assign wrap = inc && !cnt_wr && (count == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            irq   <= 1'b0;
            lost  <= 1'b0;
        end else begin
            if (cnt_wr)
                count <= cnt_wdata;
            else if (inc)
                count <= count + 1'b1;

            if (wrap)
                irq <= 1'b1;
            else if (irq_ack)
                irq <= 1'b0;

            if (lost_clr)
                lost <= 1'b0;
            else if (wrap && irq && !irq_ack)
                lost <= 1'b1;
        end
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count == $past(cnt_wdata))); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (inc && !cnt_wr) |=> (count == $past(count) + 1'b1)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!inc && !cnt_wr) |=> $stable(count)); // R2
    AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (inc && !cnt_wr && count == CNT_MAX) |=> (irq && count == '0)); // R5
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack) |=> irq); // R5
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (lost && !lost_clr) |=> lost); // R6

endmodule

// File: rtl/evc_top.sv
module evc_top
    import evc_pkg::*;
#(
    parameter int NUM_EVENTS = 8,
    parameter int CNT_W      = 16,
    parameter int PID_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [2:0]            wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic [2:0]            rd_addr,
    output logic [CNT_W-1:0]      rd_data,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic                  priv_kernel,
    input  logic [PID_W-1:0]      cur_pid,
    input  logic                  irq_ack,
    output logic                  irq
);
    localparam int SEL_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;

    logic [SEL_W-1:0] sel;
    evc_mode_t        mode;
    logic [PID_W-1:0] pid;
    logic             run;
    logic             lost_clr;
    logic             cnt_wr;
    logic             inc;
    logic [CNT_W-1:0] count;
    logic             lost;

    evc_regs #(.SEL_W(SEL_W), .PID_W(PID_W), .DATA_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sel(sel), .mode(mode), .pid(pid),
        .run(run), .lost_clr(lost_clr), .cnt_wr(cnt_wr)
    );

    evc_qual #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W), .PID_W(PID_W)) u_qual (
        .events(events), .sel(sel), .mode(mode), .pid(pid), .run(run),
        .priv_kernel(priv_kernel), .cur_pid(cur_pid), .inc(inc)
    );

    evc_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .inc(inc), .cnt_wr(cnt_wr),
        .cnt_wdata(wr_data), .irq_ack(irq_ack), .lost_clr(lost_clr),
        .count(count), .irq(irq), .lost(lost)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_SEL:  rd_data[SEL_W-1:0] = sel;
            ADR_CTRL: rd_data[2:0]       = {lost, irq, run};
            ADR_MODE: rd_data[2:0]       = mode;
            ADR_PID:  rd_data[PID_W-1:0] = pid;
            ADR_CNT:  rd_data            = count;
            default:  rd_data            = '0;
        endcase
    end

    AST_STOPPED_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(count)); // R2

endmodule

// File: tb/evc_top_tb.sv
module evc_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  events = '0;
    logic        priv_kernel = 1'b0;
    logic [7:0]  cur_pid = '0;
    logic        irq_ack = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    evc_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .events(events), .priv_kernel(priv_kernel), .cur_pid(cur_pid),
        .irq_ack(irq_ack), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state, R9 map
        rd_check("R8 sel", 3'd0, 16'h0000);
        rd_check("R8 status", 3'd1, 16'h0000);
        rd_check("R8 mode", 3'd2, 16'h0003);
        rd_check("R8 pid", 3'd3, 16'h0000);
        rd_check("R8 count", 3'd4, 16'h0000);
        check("R8 irq", {15'd0, irq}, 16'h0000);

        // R1 R3 R4 exhaustive qualification sweep
        wr(3'd1, 16'h0001);
        for (int e = 0; e < 8; e++) begin
            for (int m = 0; m < 8; m++) begin
                for (int k = 0; k < 2; k++) begin
                    for (int hit = 0; hit < 2; hit++) begin
                        logic [7:0] pv;
                        bit ok;
                        pv = 8'(e * 17 + m * 3 + 1);
                        wr(3'd0, 16'(e));
                        wr(3'd2, 16'(m));
                        wr(3'd3, {8'd0, pv});
                        wr(3'd4, 16'h0000);
                        priv_kernel = k[0];
                        cur_pid = hit ? pv : (pv ^ 8'h5A);
                        ok = (k ? m[1] : m[0]) && (!m[2] || hit != 0);
                        events = 8'(1 << e);
                        @(negedge clk);
                        events = ~8'(1 << e);
                        @(negedge clk);
                        events = '0;
                        rd_check($sformatf("R1/R3/R4 e%0d m%0d k%0d hit%0d", e, m, k, hit),
                                 3'd4, ok ? 16'h0001 : 16'h0000);
                    end
                end
            end
        end
        rd_check("R9 mode readback", 3'd2, 16'h0007);
        rd_check("R9 sel readback", 3'd0, 16'h0007);

        // R2 start and stop timing
        wr(3'd1, 16'h0002);
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0003);
        wr(3'd4, 16'h0000);
        events = 8'h01;
        wr(3'd1, 16'h0001);
        repeat (3) @(negedge clk);
        events = '0;
        rd_check("R2 start next cycle", 3'd4, 16'h0003);
        events = 8'h01;
        wr(3'd1, 16'h0002);
        repeat (3) @(negedge clk);
        events = '0;
        rd_check("R2 stop holds count", 3'd4, 16'h0005);
        rd_check("R2 stopped status", 3'd1, 16'h0000);
        wr(3'd1, 16'h0003);
        rd_check("R2 stop priority", 3'd1, 16'h0000);

        // R7 write wins over same-cycle event
        wr(3'd1, 16'h0001);
        events = 8'h01;
        wr(3'd4, 16'h1234);
        events = '0;
        rd_check("R7 write wins", 3'd4, 16'h1234);

        // R5 wrap and interrupt
        wr(3'd4, 16'hFFFE);
        events = 8'h01;
        repeat (2) @(negedge clk);
        events = '0;
        rd_check("R5 wrap to zero", 3'd4, 16'h0000);
        check("R5 irq raised", {15'd0, irq}, 16'h0001);
        repeat (3) @(negedge clk);
        check("R5 irq held", {15'd0, irq}, 16'h0001);

        // R6 lost overflow
        wr(3'd4, 16'hFFFF);
        events = 8'h01;
        @(negedge clk);
        events = '0;
        rd_check("R6 lost set", 3'd1, 16'h0007);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R5 irq cleared by ack", {15'd0, irq}, 16'h0000);
        rd_check("R6 lost survives ack", 3'd1, 16'h0005);
        wr(3'd1, 16'h0004);
        rd_check("R6 lost cleared, run kept", 3'd1, 16'h0001);

        // R5 wrap in the same cycle as ack keeps irq; no lost
        wr(3'd4, 16'hFFFF);
        events = 8'h01;
        @(negedge clk);
        events = '0;
        wr(3'd4, 16'hFFFF);
        events = 8'h01; irq_ack = 1'b1;
        @(negedge clk);
        events = '0; irq_ack = 1'b0;
        rd_check("R5 wrap beats ack", 3'd1, 16'h0003);

        // R9 unused addresses
        rd_check("R9 addr5", 3'd5, 16'h0000);
        rd_check("R9 addr6", 3'd6, 16'h0000);
        rd_check("R9 addr7", 3'd7, 16'h0000);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule